// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block holds three independent 32-bit down-counters behind a small register interface. Each channel keeps a live count, a reload constant and a control word. A shared start register gates each channel separately. When a running channel counts past zero, it takes the reload constant as its new count in that same step. It also sets a sticky underflow flag and, if enabled, raises its own interrupt line. With this reload, a constant of C gives a period of C+1 count clocks.

Each channel picks its own count clock. It can use the system clock divided by 4, 16, 64 or 256 from one shared free-running prescaler. It can also use edges of an external clock pin, which is passed through two synchroniser flops. The edge that counts may be rising, falling or both. Channel 2 alone has a capture unit. On a chosen edge of a separate capture pin, it copies the live count into a capture register and sets a capture flag, and it can raise an interrupt.

Writes use `reg_we`, `reg_waddr` and `reg_wdata`, and take effect at the next clock edge. Reads are combinational from `reg_raddr`.

Top module: `tmr_trio`

## Requirements
- R1: After reset every register reads 0 and all interrupt outputs are 0.
- R2: The start register at address 0 holds one start bit per channel in bits [2:0]. A channel whose start bit is 0 keeps its count no matter what clock or pin activity occurs.
- R3: A running channel decrements on each selected count clock. A count clock that arrives while the count is 0 loads the reload constant instead, so the underflow period is constant+1 count clocks.
- R4: Control bits [2:0] select the count clock. Values 0, 1, 2 and 3 select the system clock divided by 4, 16, 64 and 256. Values 4 to 7 select the external clock pin.
- R5: Control bits [4:3] select the active edge of the synchronised pins. 00 is rising, 01 is falling, and 10 or 11 is both edges.
- R6: Control bit 6 is the underflow flag, set by every underflow. Writing 0 to it clears it and writing 1 leaves it unchanged. A simultaneous underflow wins over a clear.
- R7: Interrupt `irq_unf[n]` is high exactly while channel n's underflow flag and its enable bit (control bit 5) are both 1.
- R8: On channel 2, control bit 7 enables capture. An active edge on the capture pin, chosen by bits [4:3], copies the count into the capture register at address 10 and sets the capture flag (control bit 9). Writing 0 to bit 9 clears the flag.
- R9: `irq_cap` is high while channel 2's capture flag and its capture interrupt enable (control bit 8) are both 1.
- R10: On channels 0 and 1, control bits [9:7] always read 0. Bits above 9 read 0 on all channels.
- R11: Channel n's constant, count and control registers sit at addresses 1+3n, 2+3n and 3+3n. A write to a count register replaces the count at the next clock edge and takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read address |
| reg_rdata | output | 32 | Read data for `reg_raddr` |
| ext_clk_pin | input | 1 | External count clock pin |
| cap_pin | input | 1 | Capture trigger pin (channel 2) |
| irq_unf | output | 3 | Per-channel underflow interrupt |
| irq_cap | output | 1 | Channel 2 capture interrupt |

## Verification
The bench builds the block with its default parameters: three channels, 32-bit counters, channel 2 as the capture channel and a two-stage synchroniser. With these values, all four prescale taps can be measured as exact underflow-to-underflow intervals within a few hundred cycles. The external pin lets the bench place each count event, so reload, edge selection and capture values are exact. Small reload constants bring underflow within reach. Keeping channel 2 stopped while capturing holds the captured value fixed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // prescaler: DIV_CHOICES taps, each 4x slower than the previous
  localparam int DIV_CHOICES = 4;
  localparam int PRE_W       = 2 * DIV_CHOICES;
  localparam int DATA_W      = 32;

  // register layout
  localparam int REG_START = 0;
  localparam int CH_BASE   = 1;
  localparam int CH_STRIDE = 3;
  localparam int OFF_CONST = 0;
  localparam int OFF_COUNT = 1;
  localparam int OFF_CTRL  = 2;

  // control word bit positions
  localparam int B_IE    = 5;
  localparam int B_UNF   = 6;
  localparam int B_CAPEN = 7;
  localparam int B_CAPIE = 8;
  localparam int B_CAPF  = 9;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_ANY  = 2'b10,
    EDGE_ANY2 = 2'b11
  } edge_mode_e;

  function automatic logic edge_hit(input logic [1:0] mode, input logic rise, input logic fall);
    case (edge_mode_e'(mode))
      EDGE_RISE: return rise;
      EDGE_FALL: return fall;
      default:   return rise | fall;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int TAPS = DIV_CHOICES
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TAPS-1:0] tick
);
  localparam int W = 2 * TAPS;

  logic [W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // tap k pulses once every 4^(k+1) cycles
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tick[k] = &pre_q[2*k+1:0];
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit HAS_CAP = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DIV_CHOICES-1:0] pre_tick,
  input  logic                   ext_rise,
  input  logic                   ext_fall,
  input  logic                   cap_rise,
  input  logic                   cap_fall,
  input  logic                   run,
  input  logic                   wr_const,
  input  logic                   wr_cnt,
  input  logic                   wr_ctrl,
  input  logic [DATA_W-1:0]      wdata,
  output logic [CNT_W-1:0]       cnt_o,
  output logic [CNT_W-1:0]       const_o,
  output logic [DATA_W-1:0]      ctrl_o,
  output logic                   tick_o,
  output logic                   unf_o,
  output logic                   flag_o,
  output logic                   ie_o,
  output logic                   irq_o,
  output logic                   cap_evt_o,
  output logic                   capf_o,
  output logic                   cap_irq_o,
  output logic [CNT_W-1:0]       cap_o
);
  logic [CNT_W-1:0] cnt_q, const_q;
  logic [2:0]       sel_q;
  logic [1:0]       edge_q;
  logic             ie_q, flag_q;
  logic             capen_w, capie_w;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic [CNT_W-1:0] rl);
    return (cur == '0) ? rl : cur - 1'b1;
  endfunction

  assign tick_o = sel_q[2] ? edge_hit(edge_q, ext_rise, ext_fall)
                           : pre_tick[sel_q[1:0]];
  assign unf_o  = run & tick_o & (cnt_q == '0) & ~wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      const_q <= '0;
      sel_q   <= '0;
      edge_q  <= '0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_const) const_q <= wdata[CNT_W-1:0];
      if (wr_cnt)             cnt_q <= wdata[CNT_W-1:0];
      else if (run && tick_o) cnt_q <= step(cnt_q, const_q);
      if (wr_ctrl) begin
        sel_q  <= wdata[2:0];
        edge_q <= wdata[4:3];
        ie_q   <= wdata[B_IE];
      end
      if (unf_o)                        flag_q <= 1'b1;
      else if (wr_ctrl && !wdata[B_UNF]) flag_q <= 1'b0;
    end
  end

  if (HAS_CAP) begin : g_cap
    logic             capen_q, capie_q, capf_q;
    logic [CNT_W-1:0] cap_q;

    assign cap_evt_o = capen_q & edge_hit(edge_q, cap_rise, cap_fall);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        capen_q <= 1'b0;
        capie_q <= 1'b0;
        capf_q  <= 1'b0;
        cap_q   <= '0;
      end else begin
        if (wr_ctrl) begin
          capen_q <= wdata[B_CAPEN];
          capie_q <= wdata[B_CAPIE];
        end
        if (cap_evt_o) begin
          cap_q  <= cnt_q;
          capf_q <= 1'b1;
        end else if (wr_ctrl && !wdata[B_CAPF]) begin
          capf_q <= 1'b0;
        end
      end
    end

    assign capen_w   = capen_q;
    assign capie_w   = capie_q;
    assign capf_o    = capf_q;
    assign cap_o     = cap_q;
    assign cap_irq_o = capf_q & capie_q;
  end else begin : g_nocap
    logic unused_cap_pins;
    assign unused_cap_pins = cap_rise ^ cap_fall;
    assign cap_evt_o = 1'b0;
    assign capen_w   = 1'b0;
    assign capie_w   = 1'b0;
    assign capf_o    = 1'b0;
    assign cap_o     = '0;
    assign cap_irq_o = 1'b0;
  end

  always_comb begin
    ctrl_o          = '0;
    ctrl_o[2:0]     = sel_q;
    ctrl_o[4:3]     = edge_q;
    ctrl_o[B_IE]    = ie_q;
    ctrl_o[B_UNF]   = flag_q;
    ctrl_o[B_CAPEN] = capen_w;
    ctrl_o[B_CAPIE] = capie_w;
    ctrl_o[B_CAPF]  = capf_o;
  end

  assign cnt_o   = cnt_q;
  assign const_o = const_q;
  assign flag_o  = flag_q;
  assign ie_o    = ie_q;
  assign irq_o   = flag_q & ie_q;
endmodule

// File: rtl/tmr_trio.sv
module tmr_trio
  import tmr_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int CNT_W       = 32,
  parameter int CAP_CH      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_clk_pin,
  input  logic              cap_pin,
  output logic [NUM_CH-1:0] irq_unf,
  output logic              irq_cap
);
  localparam int REG_CAP = CH_BASE + CH_STRIDE * NUM_CH;

  logic [DIV_CHOICES-1:0]         pre_tick;
  logic                           ext_rise, ext_fall, cap_rise, cap_fall;
  logic [NUM_CH-1:0]              start_q;
  logic [NUM_CH-1:0][CNT_W-1:0]   cnt_q, const_q, cap_all;
  logic [NUM_CH-1:0][DATA_W-1:0]  ctrl_all;
  logic [NUM_CH-1:0]              tick_w, unf_w, flag_w, ie_w;
  logic [NUM_CH-1:0]              capevt_all, capf_all, capirq_all;
  logic                           cap_evt_w, capf_w;
  logic [CNT_W-1:0]               cap_val;
  logic                           unused_ok;

  tmr_prescaler #(.TAPS(DIV_CHOICES)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk_pin), .rise(ext_rise), .fall(ext_fall)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise(cap_rise), .fall(cap_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= '0;
    else if (reg_we && reg_waddr == ADDR_W'(REG_START)) start_q <= reg_wdata[NUM_CH-1:0];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STRIDE * n;
    logic wr_const, wr_cnt, wr_ctrl;
    assign wr_const = reg_we && reg_waddr == ADDR_W'(BASE + OFF_CONST);
    assign wr_cnt   = reg_we && reg_waddr == ADDR_W'(BASE + OFF_COUNT);
    assign wr_ctrl  = reg_we && reg_waddr == ADDR_W'(BASE + OFF_CTRL);

    tmr_channel #(.CNT_W(CNT_W), .HAS_CAP(n == CAP_CH)) u_ch (
      .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick),
      .ext_rise(ext_rise), .ext_fall(ext_fall),
      .cap_rise(cap_rise), .cap_fall(cap_fall),
      .run(start_q[n]), .wr_const(wr_const), .wr_cnt(wr_cnt), .wr_ctrl(wr_ctrl),
      .wdata(reg_wdata),
      .cnt_o(cnt_q[n]), .const_o(const_q[n]), .ctrl_o(ctrl_all[n]),
      .tick_o(tick_w[n]), .unf_o(unf_w[n]), .flag_o(flag_w[n]), .ie_o(ie_w[n]),
      .irq_o(irq_unf[n]),
      .cap_evt_o(capevt_all[n]), .capf_o(capf_all[n]), .cap_irq_o(capirq_all[n]),
      .cap_o(cap_all[n])
    );
  end

  assign cap_evt_w = capevt_all[CAP_CH];
  assign capf_w    = capf_all[CAP_CH];
  assign cap_val   = cap_all[CAP_CH];
  assign irq_cap   = capirq_all[CAP_CH];
  assign unused_ok = ^{cap_all, capevt_all, capf_all, capirq_all};

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == ADDR_W'(REG_START)) reg_rdata[NUM_CH-1:0] = start_q;
    if (reg_raddr == ADDR_W'(REG_CAP))   reg_rdata = DATA_W'(cap_val);
    for (int n = 0; n < NUM_CH; n++) begin
      if (reg_raddr == ADDR_W'(CH_BASE + CH_STRIDE * n + OFF_CONST)) reg_rdata = DATA_W'(const_q[n]);
      if (reg_raddr == ADDR_W'(CH_BASE + CH_STRIDE * n + OFF_COUNT)) reg_rdata = DATA_W'(cnt_q[n]);
      if (reg_raddr == ADDR_W'(CH_BASE + CH_STRIDE * n + OFF_CTRL))  reg_rdata = ctrl_all[n];
    end
  end
endmodule

// File: rtl/tmr_trio_chk.sv
module tmr_trio_chk
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int CAP_CH = 2,
  parameter int ADDR_W = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         reg_we,
  input logic [ADDR_W-1:0]            reg_waddr,
  input logic [DATA_W-1:0]            reg_wdata,
  input logic [NUM_CH-1:0]            start_q,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_q,
  input logic [NUM_CH-1:0][CNT_W-1:0] const_q,
  input logic [NUM_CH-1:0]            tick_w,
  input logic [NUM_CH-1:0]            unf_w,
  input logic [NUM_CH-1:0]            flag_w,
  input logic [NUM_CH-1:0]            ie_w,
  input logic [NUM_CH-1:0]            irq_unf,
  input logic                         cap_evt_w,
  input logic                         capf_w,
  input logic [CNT_W-1:0]             cap_val
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    logic wr_cnt, wr_ctrl;
    assign wr_cnt  = reg_we && reg_waddr == ADDR_W'(CH_BASE + CH_STRIDE * n + OFF_COUNT);
    assign wr_ctrl = reg_we && reg_waddr == ADDR_W'(CH_BASE + CH_STRIDE * n + OFF_CTRL);

    p_hold_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_q[n] && !wr_cnt) |=> $stable(cnt_q[n]));

    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q[n] && tick_w[n] && cnt_q[n] != '0 && !wr_cnt) |=> cnt_q[n] == $past(cnt_q[n]) - 1'b1);

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      unf_w[n] |=> cnt_q[n] == $past(const_q[n]));

    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      unf_w[n] |=> flag_w[n]);

    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !reg_wdata[B_UNF] && !unf_w[n]) |=> !flag_w[n]);

    p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_w[n] && ie_w[n] && !wr_ctrl) |=> irq_unf[n]);
  end

  p_capture_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_w |=> (cap_val == $past(cnt_q[CAP_CH]) && capf_w));
endmodule

bind tmr_trio tmr_trio_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .CAP_CH(CAP_CH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
  .start_q(start_q), .cnt_q(cnt_q), .const_q(const_q), .tick_w(tick_w), .unf_w(unf_w),
  .flag_w(flag_w), .ie_w(ie_w), .irq_unf(irq_unf), .cap_evt_w(cap_evt_w),
  .capf_w(capf_w), .cap_val(cap_val)
);

// File: tb/test_tmr_trio.sv
module test_tmr_trio;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        ext_clk_pin = 1'b0;
  logic        cap_pin = 1'b0;
  logic [2:0]  irq_unf;
  logic        irq_cap;

  int n_total = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  // scoreboard queues: kind 0 = register read, 1 = irq_unf, 2 = irq_cap, 3 = measured value
  int          kind_q[$];
  logic [3:0]  addr_q[$];
  logic [31:0] exp_q[$];
  logic [31:0] meas_q[$];
  string       tag_q[$];

  tmr_trio i_tmr_trio (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .ext_clk_pin(ext_clk_pin), .cap_pin(cap_pin), .irq_unf(irq_unf), .irq_cap(irq_cap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expectations and compares with what the design shows
  initial begin
    forever begin
      int          k;
      logic [31:0] act, expv;
      string       tg;
      wait (kind_q.size() != 0);
      k = kind_q.pop_front();
      expv = exp_q.pop_front();
      tg = tag_q.pop_front();
      reg_raddr = addr_q.pop_front();
      act = meas_q.pop_front();
      #1;
      case (k)
        0: act = reg_rdata;
        1: act = {29'b0, irq_unf};
        2: act = {31'b0, irq_cap};
        default: ;
      endcase
      n_total++;
      if (act !== expv) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", tg, act, expv);
      end
    end
  end

  task automatic push(input int k, input logic [3:0] a, input logic [31:0] m,
                      input logic [31:0] e, input string tg);
    kind_q.push_back(k);
    addr_q.push_back(a);
    meas_q.push_back(m);
    exp_q.push_back(e);
    tag_q.push_back(tg);
    wait (kind_q.size() == 0);
    #2;
  endtask

  task automatic chk_reg(input logic [3:0] a, input logic [31:0] e, input string tg);
    push(0, a, '0, e, tg);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_ext();
    ext_clk_pin = 1'b1; repeat (5) @(negedge clk);
    ext_clk_pin = 1'b0; repeat (5) @(negedge clk);
  endtask

  task automatic pulse_cap();
    cap_pin = 1'b1; repeat (5) @(negedge clk);
    cap_pin = 1'b0; repeat (5) @(negedge clk);
  endtask

  task automatic wait_irq0();
    while (!irq_unf[0]) @(negedge clk);
  endtask

  // R3/R4: interval between two underflows must be divisor*(c+1) cycles
  task automatic period(input logic [2:0] sel, input int c, input int expect_cyc, input string tg);
    int t1;
    wr(4'd0, 32'd0);
    wr(4'd1, c);
    wr(4'd2, c);
    wr(4'd3, 32'h20 | sel);
    wr(4'd0, 32'd1);
    wait_irq0();
    wr(4'd3, 32'h20 | sel);
    wait_irq0();
    t1 = cyc;
    wr(4'd3, 32'h20 | sel);
    wait_irq0();
    push(3, 4'd0, cyc - t1, expect_cyc, tg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 11; a++) chk_reg(a[3:0], 32'h0, "R1 reset register value");
    push(1, 4'd0, '0, 32'h0, "R1 reset irq_unf");
    push(2, 4'd0, '0, 32'h0, "R1 reset irq_cap");

    // R11 map and immediate count write
    wr(4'd1, 32'hDEAD_BEEF);
    chk_reg(4'd1, 32'hDEAD_BEEF, "R11 constant readback ch0");
    wr(4'd5, 32'h0000_0077);
    chk_reg(4'd5, 32'h0000_0077, "R11 count write ch1");

    // R4 prescale taps via underflow interval
    period(3'd0, 3, 16,  "R4 div4 period R3");
    period(3'd1, 2, 48,  "R4 div16 period");
    period(3'd2, 1, 128, "R4 div64 period");
    period(3'd3, 0, 256, "R4 div256 period");
    wr(4'd0, 32'd0);
    wr(4'd3, 32'd0);
    push(1, 4'd0, '0, 32'h0, "R7 irq drops after flag clear");

    // R10/R6: ch0 has no capture bits; writing 1 to the flag does not set it
    wr(4'd3, 32'h0000_03FF);
    chk_reg(4'd3, 32'h0000_003F, "R10 ch0 control mask R6");
    push(1, 4'd0, '0, 32'h0, "R7 no irq without flag");
    wr(4'd3, 32'd0);

    // R3/R5 external rising edges on ch1: 2 -> 1 -> 0 -> reload 3
    wr(4'd4, 32'd3);
    wr(4'd5, 32'd2);
    wr(4'd6, 32'h24);
    wr(4'd0, 32'b010);
    chk_reg(4'd0, 32'b010, "R2 start readback");
    repeat (3) pulse_ext();
    chk_reg(4'd5, 32'd3, "R3 reload after underflow");
    chk_reg(4'd6, 32'h64, "R6 flag set on underflow");
    push(1, 4'd0, '0, 32'b010, "R7 irq_unf ch1 asserted");
    wr(4'd6, 32'h64);
    chk_reg(4'd6, 32'h64, "R6 write 1 keeps flag");
    wr(4'd6, 32'h24);
    chk_reg(4'd6, 32'h24, "R6 write 0 clears flag");
    push(1, 4'd0, '0, 32'h0, "R7 irq_unf ch1 cleared");

    wr(4'd6, 32'h2C);
    pulse_ext();
    chk_reg(4'd5, 32'd2, "R5 falling edge counts once");
    wr(4'd6, 32'h34);
    pulse_ext();
    chk_reg(4'd5, 32'd0, "R5 both edges count twice");

    wr(4'd0, 32'd0);
    pulse_ext();
    chk_reg(4'd5, 32'd0, "R2 stopped channel holds count");
    chk_reg(4'd6, 32'h34, "R2 no underflow while stopped");

    // R8/R9 capture on channel 2 (stopped so count is fixed)
    wr(4'd8, 32'h0000_1234);
    wr(4'd9, 32'h180);
    pulse_cap();
    chk_reg(4'd10, 32'h0000_1234, "R8 captured count");
    chk_reg(4'd9, 32'h380, "R8 capture flag set");
    push(2, 4'd0, '0, 32'h1, "R9 irq_cap asserted");
    wr(4'd9, 32'h180);
    chk_reg(4'd9, 32'h180, "R8 capture flag cleared");
    push(2, 4'd0, '0, 32'h0, "R9 irq_cap cleared");

    wr(4'd8, 32'h0000_ABCD);
    wr(4'd9, 32'h088);
    pulse_cap();
    chk_reg(4'd10, 32'h0000_ABCD, "R8 capture on falling edge");
    chk_reg(4'd9, 32'h288, "R8 flag with capture irq off");
    push(2, 4'd0, '0, 32'h0, "R9 no irq_cap when disabled");

    wr(4'd9, 32'h0);
    wr(4'd8, 32'h55);
    pulse_cap();
    chk_reg(4'd10, 32'h0000_ABCD, "R8 capture disabled keeps value");
    chk_reg(4'd9, 32'h0, "R8 no flag when capture disabled");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL R3 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule